// File: doc/BRIEF.md
# Rectangular-Transfer Address Sequencer

This block produces the address stream for a two-dimensional transfer of 16-bit words. It is set up with a start byte address, a per-row element count, a byte stride that is applied between elements of a row, a row count, and a byte stride that is applied when moving from the last element of one row to the first element of the next. The row stride is added to the address of the last element in place of the element stride. It is not added to a saved row base. A copy of a narrow image into a wider buffer therefore sets the row stride to the skipped bytes plus one element. For an image of 3-byte pixels that is (buffer width − image width) × 3 + 2, and the row holds width × 3 / 2 elements. Software rounds a destination start column down to an even pixel before it turns the column into a byte offset, so that the start stays word aligned.

A one-cycle `start` pulse captures the setup and begins the walk. Each address is offered on `addr_out` with `addr_valid` and is consumed when `addr_ready` is also high. In one-shot mode the sequencer stops after the last element and raises `done`. In repeat mode it goes back to the start address and the full counts straight after the last element, with no empty cycle, and it runs until `abort`. A setup with a zero count raises `err` and offers no address. Both flags stay set until a clear pulse removes them.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After a synchronous reset, `addr_valid`, `run`, `done` and `err` are all low.
- R2: A `start` pulse while `run` is low, with `abort` low and both counts non-zero, makes `addr_valid` and `run` high on the next cycle, with `addr_out` equal to the captured start address.
- R3: When an address that is not the last of its row is accepted, the next address is the accepted one plus the element stride, taken as a two's-complement value.
- R4: When the last address of a row other than the final row is accepted, the next address is the accepted one plus the row stride. The element count of the new row starts again from the configured value.
- R5: In one-shot mode (`cfg_auto` = 0 at start), acceptance of the final element (element count × row count) drops `addr_valid` and `run` on the next cycle and sets `done`.
- R6: In repeat mode (`cfg_auto` = 1 at start), the cycle after the final element is accepted offers the start address again, with `addr_valid` still high. The pattern repeats without end and `done` is never set.
- R7: A `start` with an element count or row count of zero sets `err`, leaves `run` and `addr_valid` low and offers no address.
- R8: While `addr_valid` is high and `addr_ready` is low (and `abort` is low), `addr_out` and `addr_valid` keep their values into the next cycle.
- R9: A `clr_done` or `clr_err` pulse clears its flag on the next cycle. When a flag is set and cleared in the same cycle, the set wins.
- R10: A `start` pulse while `run` is high is ignored: the address sequence and the captured setup do not change.
- R11: An `abort` pulse drops `addr_valid` and `run` on the next cycle without setting `done`. Abort takes priority over a simultaneous `start` or acceptance.
- R12: Address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | ADDR_W | Start byte address |
| cfg_x_count | input | CNT_W | Elements per row |
| cfg_x_stride | input | ADDR_W | Byte step between elements of a row (two's complement) |
| cfg_y_count | input | CNT_W | Number of rows |
| cfg_y_stride | input | ADDR_W | Byte step from the last element of a row to the next row (two's complement) |
| cfg_auto | input | 1 | 1 = repeat the pattern forever, 0 = one shot |
| start | input | 1 | Capture the setup and begin |
| abort | input | 1 | Stop the walk at once |
| clr_done | input | 1 | Clear `done` |
| clr_err | input | 1 | Clear `err` |
| addr_out | output | ADDR_W | Current byte address |
| addr_valid | output | 1 | `addr_out` is on offer |
| addr_ready | input | 1 | Consumer takes the address this cycle |
| run | output | 1 | A walk is in progress |
| done | output | 1 | A one-shot walk has finished |
| err | output | 1 | A start was refused for a zero count |

## Verification
The hardest case to reach is the last element of the final row when that acceptance also falls on a stall boundary or on a flag clear. This is where the row switch, the frame reload or stop, and the set-versus-clear priority all act in the same cycle. The stimulus gets there by running small rectangles (a few elements by a few rows) so that frame ends come often. It toggles `addr_ready` at random, holds `clr_done` high through whole transfers, and fires `start` in the middle of a transfer. A reference model in the bench follows every cycle. Fixed copy-into-buffer and wrap-around cases check the address formula itself.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    // What the address register does on a given cycle.
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,   // nothing accepted
        STEP_ELEM  = 2'd1,   // move within a row
        STEP_ROW   = 2'd2,   // move to the next row
        STEP_FRAME = 2'd3    // final element of the rectangle accepted
    } step_e;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_BUSY = 1'b1
    } walk_e;

    function automatic step_e pick_step(input logic fire,
                                        input logic last_elem,
                                        input logic last_row);
        step_e s;
        if (!fire)
            s = STEP_HOLD;
        else if (last_elem && last_row)
            s = STEP_FRAME;
        else if (last_elem)
            s = STEP_ROW;
        else
            s = STEP_ELEM;
        return s;
    endfunction

endpackage

// File: rtl/dma2d_shadow.sv
module dma2d_shadow #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [ADDR_W-1:0] in_start,
    input  logic [ADDR_W-1:0] in_xs,
    input  logic [ADDR_W-1:0] in_ys,
    input  logic [CNT_W-1:0]  in_xc,
    input  logic [CNT_W-1:0]  in_yc,
    input  logic              in_auto,
    output logic [ADDR_W-1:0] sh_start,
    output logic [ADDR_W-1:0] sh_xs,
    output logic [ADDR_W-1:0] sh_ys,
    output logic [CNT_W-1:0]  sh_xc,
    output logic [CNT_W-1:0]  sh_yc,
    output logic              sh_auto
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_start <= '0;
            sh_xs    <= '0;
            sh_ys    <= '0;
            sh_xc    <= '0;
            sh_yc    <= '0;
            sh_auto  <= 1'b0;
        end else if (capture) begin
            sh_start <= in_start;
            sh_xs    <= in_xs;
            sh_ys    <= in_ys;
            sh_xc    <= in_xc;
            sh_yc    <= in_yc;
            sh_auto  <= in_auto;
        end
    end

endmodule

// File: rtl/dma2d_walk.sv
module dma2d_walk
    import dma2d_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             fire,
    input  logic [CNT_W-1:0] ld_xc,
    input  logic [CNT_W-1:0] ld_yc,
    input  logic [CNT_W-1:0] rl_xc,
    input  logic [CNT_W-1:0] rl_yc,
    output step_e            step
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] x_left;
    logic [CNT_W-1:0] y_left;

    always_comb begin
        step = pick_step(fire, x_left == ONE, y_left == ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_left <= '0;
            y_left <= '0;
        end else if (load) begin
            x_left <= ld_xc;
            y_left <= ld_yc;
        end else begin
            unique case (step)
                STEP_ELEM:  x_left <= x_left - ONE;
                STEP_ROW: begin
                    x_left <= rl_xc;
                    y_left <= y_left - ONE;
                end
                STEP_FRAME: begin
                    x_left <= rl_xc;
                    y_left <= rl_yc;
                end
                default: ;
            endcase
        end
    end

    // R4: a row step is never taken on the final row
    a_r4_row_not_final: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_ROW) |-> (y_left != ONE));

endmodule

// File: rtl/dma2d_addr_reg.sv
module dma2d_addr_reg
    import dma2d_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  step_e             step,
    input  logic [ADDR_W-1:0] elem_stride,
    input  logic [ADDR_W-1:0] row_stride,
    input  logic [ADDR_W-1:0] frame_addr,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_nxt;

    always_comb begin
        addr_nxt = addr;
        unique case (step)
            STEP_ELEM:  addr_nxt = addr + elem_stride;
            STEP_ROW:   addr_nxt = addr + row_stride;
            STEP_FRAME: addr_nxt = frame_addr;
            default:    addr_nxt = addr;
        endcase
        if (load)
            addr_nxt = load_addr;
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else
            addr <= addr_nxt;
    end

endmodule

// File: rtl/dma2d_flags.sv
module dma2d_flags (
    input  logic clk,
    input  logic rst,
    input  logic set_done,
    input  logic set_err,
    input  logic clr_done,
    input  logic clr_err,
    output logic done,
    output logic err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            if (set_done)
                done <= 1'b1;
            else if (clr_done)
                done <= 1'b0;
            if (set_err)
                err <= 1'b1;
            else if (clr_err)
                err <= 1'b0;
        end
    end

    // R9: a clear with no simultaneous set empties the flag
    a_r9_done_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_done && !set_done) |=> !done);
    a_r9_err_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_err && !set_err) |=> !err);
    // R9: a set wins over a clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_done |=> done);

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [CNT_W-1:0]  cfg_x_count,
    input  logic [ADDR_W-1:0] cfg_x_stride,
    input  logic [CNT_W-1:0]  cfg_y_count,
    input  logic [ADDR_W-1:0] cfg_y_stride,
    input  logic              cfg_auto,
    input  logic              start,
    input  logic              abort,
    input  logic              clr_done,
    input  logic              clr_err,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_valid,
    input  logic              addr_ready,
    output logic              run,
    output logic              done,
    output logic              err
);

    walk_e             state;
    logic              accept;
    logic              cfg_ok;
    logic              load;
    logic              fire;
    step_e             step;
    logic              finish;

    logic [ADDR_W-1:0] sh_start;
    logic [ADDR_W-1:0] sh_xs;
    logic [ADDR_W-1:0] sh_ys;
    logic [CNT_W-1:0]  sh_xc;
    logic [CNT_W-1:0]  sh_yc;
    logic              sh_auto;

    always_comb begin
        cfg_ok = (cfg_x_count != '0) && (cfg_y_count != '0);
        accept = start && (state == WALK_IDLE) && !abort;
        load   = accept && cfg_ok;
        fire   = (state == WALK_BUSY) && addr_ready && !abort;
        finish = (step == STEP_FRAME) && !sh_auto;
    end

    dma2d_shadow #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .capture  (load),
        .in_start (cfg_start),
        .in_xs    (cfg_x_stride),
        .in_ys    (cfg_y_stride),
        .in_xc    (cfg_x_count),
        .in_yc    (cfg_y_count),
        .in_auto  (cfg_auto),
        .sh_start (sh_start),
        .sh_xs    (sh_xs),
        .sh_ys    (sh_ys),
        .sh_xc    (sh_xc),
        .sh_yc    (sh_yc),
        .sh_auto  (sh_auto)
    );

    dma2d_walk #(.CNT_W(CNT_W)) u_walk (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .fire  (fire),
        .ld_xc (cfg_x_count),
        .ld_yc (cfg_y_count),
        .rl_xc (sh_xc),
        .rl_yc (sh_yc),
        .step  (step)
    );

    dma2d_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .load_addr   (cfg_start),
        .step        (step),
        .elem_stride (sh_xs),
        .row_stride  (sh_ys),
        .frame_addr  (sh_start),
        .addr        (addr_out)
    );

    dma2d_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_done (finish),
        .set_err  (accept && !cfg_ok),
        .clr_done (clr_done),
        .clr_err  (clr_err),
        .done     (done),
        .err      (err)
    );

    always_ff @(posedge clk) begin
        if (rst)
            state <= WALK_IDLE;
        else if (abort)
            state <= WALK_IDLE;
        else if (load)
            state <= WALK_BUSY;
        else if (finish)
            state <= WALK_IDLE;
    end

    assign addr_valid = (state == WALK_BUSY);
    assign run        = (state == WALK_BUSY);

    // R2: a good start offers the start address on the next cycle
    a_r2_start_offer: assert property (@(posedge clk) disable iff (rst)
        (start && !run && !abort && cfg_x_count != '0 && cfg_y_count != '0)
        |=> (addr_valid && run && addr_out == $past(cfg_start)));

    // R5: the final one-shot acceptance stops the walk and raises done
    a_r5_finish_stops: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_ready && !abort && step == STEP_FRAME && !sh_auto)
        |=> (!addr_valid && !run && done));

    // R6: repeat mode goes back to the start address with no gap
    a_r6_restart_no_gap: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_ready && !abort && step == STEP_FRAME && sh_auto)
        |=> (addr_valid && addr_out == sh_start));

    // R7: a zero count refuses the start
    a_r7_zero_refused: assert property (@(posedge clk) disable iff (rst)
        (start && !run && !abort && (cfg_x_count == '0 || cfg_y_count == '0))
        |=> (err && !addr_valid && !run));

    // R8: a stalled offer is held
    a_r8_hold_offer: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !addr_ready && !abort)
        |=> (addr_valid && $stable(addr_out)));

    // R11: abort empties the output and leaves done alone
    a_r11_abort: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!addr_valid && !run && (done == $past(done && !clr_done))));

endmodule

// File: tb/dma2d_addr_gen_test.sv
module dma2d_addr_gen_test;

    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] cfg_start = '0;
    logic [CW-1:0] cfg_x_count = '0;
    logic [AW-1:0] cfg_x_stride = '0;
    logic [CW-1:0] cfg_y_count = '0;
    logic [AW-1:0] cfg_y_stride = '0;
    logic          cfg_auto = 1'b0;
    logic          start = 1'b0;
    logic          abort = 1'b0;
    logic          clr_done = 1'b0;
    logic          clr_err = 1'b0;
    logic          addr_ready = 1'b0;
    logic [AW-1:0] addr_out;
    logic          addr_valid;
    logic          run;
    logic          done;
    logic          err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // fired addresses, recorded just before the edge that consumes them
    logic [AW-1:0] fired[$];

    // reference model state
    logic          m_act = 1'b0, m_auto = 1'b0, m_done = 1'b0, m_err = 1'b0;
    logic [AW-1:0] m_addr = '0, m_start = '0, m_xs = '0, m_ys = '0;
    int            m_xc = 0, m_yc = 0, m_xi = 0, m_yi = 0;

    always #4 clk = ~clk;

    dma2d_addr_gen #(.ADDR_W(AW), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst),
        .cfg_start(cfg_start), .cfg_x_count(cfg_x_count), .cfg_x_stride(cfg_x_stride),
        .cfg_y_count(cfg_y_count), .cfg_y_stride(cfg_y_stride), .cfg_auto(cfg_auto),
        .start(start), .abort(abort), .clr_done(clr_done), .clr_err(clr_err),
        .addr_out(addr_out), .addr_valid(addr_valid), .addr_ready(addr_ready),
        .run(run), .done(done), .err(err)
    );

    always @(posedge clk) begin
        logic nd, ne;
        if (rst) begin
            m_act = 0; m_done = 0; m_err = 0; m_addr = '0;
        end else begin
            nd = m_done; ne = m_err;
            if (clr_done) nd = 0;
            if (clr_err)  ne = 0;
            if (abort) begin
                m_act = 0;
            end else if (m_act) begin
                if (addr_ready) begin
                    if (m_xi == m_xc - 1) begin
                        if (m_yi == m_yc - 1) begin
                            if (m_auto) begin
                                m_addr = m_start; m_xi = 0; m_yi = 0;
                            end else begin
                                m_act = 0; nd = 1;
                            end
                        end else begin
                            m_addr = m_addr + m_ys; m_xi = 0; m_yi = m_yi + 1;
                        end
                    end else begin
                        m_addr = m_addr + m_xs; m_xi = m_xi + 1;
                    end
                end
            end else if (start) begin
                if (cfg_x_count == 0 || cfg_y_count == 0) begin
                    ne = 1;
                end else begin
                    m_act = 1; m_start = cfg_start; m_addr = cfg_start;
                    m_xs = cfg_x_stride; m_ys = cfg_y_stride; m_auto = cfg_auto;
                    m_xc = int'(cfg_x_count); m_yc = int'(cfg_y_count);
                    m_xi = 0; m_yi = 0;
                end
            end
            m_done = nd; m_err = ne;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(cur_req, "valid", 64'(addr_valid), 64'(m_act));
        chk(cur_req, "run",   64'(run),        64'(m_act));
        chk(cur_req, "done",  64'(done),       64'(m_done));
        chk(cur_req, "err",   64'(err),        64'(m_err));
        if (m_act) chk(cur_req, "addr", 64'(addr_out), 64'(m_addr));
    endtask

    task automatic tick();
        if (addr_valid && addr_ready && !abort) fired.push_back(addr_out);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic setup(input logic [AW-1:0] s, input int xc, input logic [AW-1:0] xs,
                         input int yc, input logic [AW-1:0] ys, input logic au);
        cfg_start = s; cfg_x_count = CW'(xc); cfg_x_stride = xs;
        cfg_y_count = CW'(yc); cfg_y_stride = ys; cfg_auto = au;
    endtask

    task automatic pulse_start();
        start = 1; tick(); start = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1; tick(); tick();
        rst = 0;
        cur_req = "R1";
        chk("R1", "valid after reset", 64'(addr_valid), 0);
        chk("R1", "done after reset", 64'(done), 0);
        chk("R1", "err after reset", 64'(err), 0);
        tick();

        // R2 R3 R4 R5: copy of a 4-pixel x 3-row 3-byte image into a 10-pixel buffer
        cur_req = "R3";
        setup(32'h1000, 6, 32'd2, 3, 32'd20, 0);
        addr_ready = 1;
        pulse_start();
        chk("R2", "start address", 64'(addr_out), 64'h1000);
        fired.delete();
        for (int k = 0; k < 25 && run; k++) tick();
        chk("R5", "element count", 64'(fired.size()), 18);
        for (int k = 0; k < fired.size(); k++)
            chk((k % 6 == 0 && k > 0) ? "R4" : "R3", "blit addr",
                64'(fired[k]), 64'(32'h1000 + (k / 6) * 30 + (k % 6) * 2));
        chk("R5", "done raised", 64'(done), 1);
        chk("R5", "run low", 64'(run), 0);

        // R9 clear done
        cur_req = "R9";
        clr_done = 1; tick(); clr_done = 0;
        chk("R9", "done cleared", 64'(done), 0);

        // R7 zero count
        cur_req = "R7";
        setup(32'h2000, 0, 32'd2, 4, 32'd2, 0);
        pulse_start();
        chk("R7", "err on zero x", 64'(err), 1);
        chk("R7", "no offer", 64'(addr_valid), 0);
        tick();
        chk("R7", "still idle", 64'(run), 0);
        clr_err = 1; tick(); clr_err = 0;
        chk("R9", "err cleared", 64'(err), 0);
        setup(32'h2000, 3, 32'd2, 0, 32'd2, 0);
        pulse_start();
        chk("R7", "err on zero y", 64'(err), 1);
        clr_err = 1; tick(); clr_err = 0;

        // R8 stall hold, R10 start while running, R9 set wins with clear held
        cur_req = "R8";
        setup(32'h3000, 3, 32'd2, 2, 32'd10, 0);
        addr_ready = 0;
        pulse_start();
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R8", "held addr", 64'(addr_out), 64'h3000);
        end
        cur_req = "R10";
        setup(32'h9000, 1, 32'd4, 1, 32'd4, 1);
        start = 1; addr_ready = 1; tick(); start = 0;
        chk("R10", "start ignored", 64'(addr_out), 64'h3002);
        cur_req = "R9";
        clr_done = 1;
        fired.delete();
        for (int k = 0; k < 10 && run; k++) tick();
        chk("R9", "set wins over clear", 64'(done), 1);
        tick();
        chk("R9", "clear after set", 64'(done), 0);
        clr_done = 0;
        chk("R10", "first setup kept", 64'(fired[fired.size()-1]), 64'h3000 + 4 + 10 + 4);

        // R6 repeat mode with random stalls, then R11 abort
        cur_req = "R6";
        setup(32'h4000, 3, 32'd2, 2, 32'd6, 1);
        pulse_start();
        fired.delete();
        for (int k = 0; k < 60; k++) begin
            addr_ready = ($urandom % 3) != 0;
            tick();
        end
        for (int k = 0; k < fired.size(); k++)
            chk("R6", "repeat addr", 64'(fired[k]),
                64'(32'h4000 + ((k % 6) / 3) * 10 + (k % 3) * 2));
        chk("R6", "no done in repeat", 64'(done), 0);
        // no gap: stream with ready high gives 12 acceptances in 12 cycles
        addr_ready = 1; fired.delete();
        for (int k = 0; k < 12; k++) tick();
        chk("R6", "no gap", 64'(fired.size()), 12);
        cur_req = "R11";
        abort = 1; start = 1; tick(); abort = 0; start = 0;
        chk("R11", "abort drops valid", 64'(addr_valid), 0);
        chk("R11", "abort no done", 64'(done), 0);
        tick();

        // R12 wrap
        cur_req = "R12";
        setup(32'hFFFF_FFFC, 4, 32'd2, 1, 32'd2, 0);
        fired.delete();
        pulse_start();
        for (int k = 0; k < 8 && run; k++) tick();
        chk("R12", "wrap count", 64'(fired.size()), 4);
        chk("R12", "wrapped addr", 64'(fired[2]), 64'h0);
        chk("R12", "wrapped addr", 64'(fired[3]), 64'h2);
        clr_done = 1; tick(); clr_done = 0;

        // R3 R4 R8 random one-shot rectangles with negative row strides
        for (int t = 0; t < 40; t++) begin
            cur_req = "R4";
            setup($urandom, 1 + $urandom % 5, 32'd2, 1 + $urandom % 4,
                  ($urandom % 2) ? -32'($urandom % 64) : 32'($urandom % 64), 0);
            pulse_start();
            for (int k = 0; k < 200 && run; k++) begin
                addr_ready = ($urandom % 2) != 0;
                clr_done = ($urandom % 4) == 0;
                tick();
            end
            clr_done = 1; addr_ready = 0; tick(); clr_done = 0;
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule